// File: doc/BRIEF.md
# Receive Signaling Debounce Buffer

This block keeps the received four-bit robbed-bit signaling (ABCD) for a set of channels, 32 by default. Per-channel updates arrive as a strobe with a channel number and a nibble, and they are staged. When the end-of-multiframe strobe arrives, a sweep visits every channel in ascending order, one channel per clock. For each channel the sweep moves the staged nibble into a buffered input. It also refreshes a buffered output, either by direct copy or through a per-bit debounce rule that lets an output bit follow only an input that has been seen twice in a row.

A host port configures the block. It sets a per-channel debounce enable, a per-channel stack enable and the stack mode. It issues freeze-on and freeze-off commands, which drive a freeze output and block all buffer and stack updates. It reads the channel nibbles, a status word and a 32-entry stack of {channel, ABCD} records. In change mode the stack receives only the enabled channels whose output changed. In all mode it receives every enabled channel. A pending-change flag raises the interrupt output and clears when the host reads the status word.

Top module: `sig_debounce_buf`

## Requirements
- R1: After reset all staged, buffered-input and buffered-output nibbles are 0. The block is not frozen and the stack mode is change mode. All debounce and stack enables are 0. The stack is empty, irq_o is 0 and frz_o is 0.
- R2: A host read at address {2'b00, ch} returns {1'b0, output[3:0], input[3:0]} of channel ch on host_rdata_o in the cycle after host_re_i. Such a read has no side effects. Host writes to that region are ignored.
- R3: A sig_upd_i strobe stores sig_abcd_i as the staged nibble of channel sig_ch_i. The stored nibble is held until the next strobe for that channel. After each end-of-multiframe sweep, each channel's buffered input equals its staged nibble.
- R4: For a channel whose debounce enable is 0, the sweep sets the buffered output to the new input nibble.
- R5: For a channel whose debounce enable is 1, each output bit takes the new input bit when that bit equals the previous buffered input bit. Otherwise the output bit keeps its value.
- R6: A host write to address 0x60 with data bit 0 set turns frz_o on. Data bit 1 set turns frz_o off. When both bits are set, on takes priority. frz_o changes in the cycle after the write.
- R7: While frozen, a sweep changes no channel nibble and pushes nothing onto the stack.
- R8: The stack enable of channel ch is written at {2'b10, ch}, data bit 0. The mode is written at 0x61, data bit 0 (0 = change, 1 = all). In change mode an enabled channel whose buffered output changes pushes {ch, new output}. In all mode every enabled channel pushes on every sweep.
- R9: The pending flag drives irq_o. It is set when the sweep finds that a stack-enabled channel's output would change, and this holds even while frozen. A status read at 0x62 returns {overflow, empty, pending} in bits [2:0] and clears pending. A set in the same cycle wins.
- R10: A read at 0x63 pops the oldest stack entry as {ch[4:0], abcd[3:0]}. Entries come out in push order. Popping an empty stack returns 0.
- R11: When the stack holds 32 entries, further pushes are dropped and the sticky overflow status bit is set. A status read clears it.
- R12: An end-of-multiframe strobe that arrives while a sweep is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sig_upd_i | input | 1 | Per-channel signaling update strobe |
| sig_ch_i | input | 5 | Channel of the update |
| sig_abcd_i | input | 4 | New ABCD nibble |
| mf_end_i | input | 1 | End-of-multiframe strobe, starts a sweep |
| host_we_i | input | 1 | Host write strobe |
| host_re_i | input | 1 | Host read strobe |
| host_addr_i | input | 7 | Host address: region [6:5], index [4:0] |
| host_wdata_i | input | 2 | Host write data |
| host_rdata_o | output | 9 | Registered host read data |
| frz_o | output | 1 | Freeze state |
| irq_o | output | 1 | Pending-change interrupt |

## Verification
A wrong buffered-input nibble does not show on the output at once. It appears one multiframe later, when the debounce rule holds an output bit that should have moved or moves one that should have held. Channel reads expose both nibbles, so the bench reads them after every sweep. A corrupt stack pointer or count appears as records out of order, as a missing or extra record, or as wrong empty and overflow bits. These appear on the first pop or status read after the sweep that went wrong. A stuck pending flag shows on irq_o one cycle after the sweep step of the channel concerned.

// File: rtl/sdb_pkg.sv
package sdb_pkg;
  localparam int ABCD_W = 4;

  typedef enum logic [1:0] {
    RG_CHAN = 2'b00,
    RG_DEB  = 2'b01,
    RG_STK  = 2'b10,
    RG_CTL  = 2'b11
  } region_e;

  localparam logic [1:0] CTL_CMD  = 2'd0;
  localparam logic [1:0] CTL_MODE = 2'd1;
  localparam logic [1:0] CTL_STAT = 2'd2;
  localparam logic [1:0] CTL_POP  = 2'd3;
endpackage

// File: rtl/sdb_stack.sv
module sdb_stack #(
  parameter int DEPTH = 32,
  parameter int DW    = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pop_i,
  output logic [DW-1:0] pop_data_o,
  output logic          empty_o,
  output logic          drop_o
);
  localparam int AW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   count;
  logic          full, do_push, do_pop;

  assign full    = (count == (AW+1)'(DEPTH));
  assign empty_o = (count == '0);
  assign do_push = push_i && !full;
  assign do_pop  = pop_i && !empty_o;
  assign pop_data_o = empty_o ? '0 : mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      drop_o <= 1'b0;
    end else begin
      drop_o <= push_i && full;
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (push_i && full && !pop_i) |=> (count == (AW+1)'(DEPTH))) else $error("stack grew past depth"); // R11
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (rst)
    (pop_i && empty_o && !push_i) |=> empty_o) else $error("pop of empty stack moved count"); // R10
endmodule

// File: rtl/sdb_chan_bank.sv
module sdb_chan_bank
  import sdb_pkg::*;
#(
  parameter int NCH  = 32,
  parameter int CH_W = 5
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   upd_i,
  input  logic [CH_W-1:0]        upd_ch_i,
  input  logic [ABCD_W-1:0]      upd_abcd_i,
  input  logic                   mf_end_i,
  input  logic                   frozen_i,
  input  logic                   all_mode_i,
  input  logic [NCH-1:0]         deb_en_i,
  input  logic [NCH-1:0]         stk_en_i,
  input  logic [CH_W-1:0]        rd_ch_i,
  output logic [2*ABCD_W-1:0]    rd_nib_o,
  output logic                   push_o,
  output logic [CH_W+ABCD_W-1:0] push_data_o,
  output logic                   change_o
);
  logic [ABCD_W-1:0] stage_q [NCH];
  logic [ABCD_W-1:0] in_q    [NCH];
  logic [ABCD_W-1:0] out_q   [NCH];
  logic              busy_q;
  logic [CH_W-1:0]   idx_q;

  logic [ABCD_W-1:0] cur_new, cur_in, cur_out, deb_out, nxt_out;
  logic              changed;

  assign cur_new = stage_q[idx_q];
  assign cur_in  = in_q[idx_q];
  assign cur_out = out_q[idx_q];

  for (genvar b = 0; b < ABCD_W; b++) begin : g_deb
    assign deb_out[b] = (cur_new[b] == cur_in[b]) ? cur_new[b] : cur_out[b];
  end

  assign nxt_out  = deb_en_i[idx_q] ? deb_out : cur_new;
  assign changed  = (nxt_out != cur_out);
  assign rd_nib_o = {out_q[rd_ch_i], in_q[rd_ch_i]};

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NCH; i++) stage_q[i] <= '0;
    end else if (upd_i) begin
      stage_q[upd_ch_i] <= upd_abcd_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NCH; i++) begin
        in_q[i]  <= '0;
        out_q[i] <= '0;
      end
    end else if (busy_q && !frozen_i) begin
      in_q[idx_q]  <= cur_new;
      out_q[idx_q] <= nxt_out;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q      <= 1'b0;
      idx_q       <= '0;
      push_o      <= 1'b0;
      push_data_o <= '0;
      change_o    <= 1'b0;
    end else begin
      push_o      <= busy_q && !frozen_i && stk_en_i[idx_q] && (all_mode_i || changed);
      push_data_o <= {idx_q, nxt_out};
      change_o    <= busy_q && stk_en_i[idx_q] && changed;
      if (busy_q) begin
        if (idx_q == CH_W'(NCH-1)) begin
          busy_q <= 1'b0;
          idx_q  <= '0;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end else if (mf_end_i) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
      end
    end
  end

  AST_SWEEP_ENDS: assert property (@(posedge clk) disable iff (rst)
    (busy_q && idx_q == CH_W'(NCH-1)) |=> !busy_q) else $error("sweep overran"); // R12
  AST_SWEEP_STEP: assert property (@(posedge clk) disable iff (rst)
    (busy_q && idx_q != CH_W'(NCH-1)) |=> (busy_q && idx_q == $past(idx_q) + 1'b1)) else $error("sweep skipped"); // R12
  AST_DEB_AGREE: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !frozen_i && deb_en_i[idx_q] && cur_new == cur_in)
      |=> (out_q[$past(idx_q)] == $past(cur_new))) else $error("debounce did not follow"); // R5
endmodule

// File: rtl/sdb_host.sv
module sdb_host
  import sdb_pkg::*;
#(
  parameter int NCH  = 32,
  parameter int CH_W = 5,
  parameter int DW   = 9
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                we_i,
  input  logic                re_i,
  input  logic [CH_W+1:0]     addr_i,
  input  logic [1:0]          wdata_i,
  input  logic [2*ABCD_W-1:0] rd_nib_i,
  input  logic [DW-1:0]       pop_data_i,
  input  logic                empty_i,
  input  logic                drop_i,
  input  logic                change_i,
  output logic [CH_W-1:0]     rd_ch_o,
  output logic                pop_o,
  output logic                frozen_o,
  output logic                all_mode_o,
  output logic [NCH-1:0]      deb_en_o,
  output logic [NCH-1:0]      stk_en_o,
  output logic [DW-1:0]       rdata_o,
  output logic                irq_o
);
  region_e          region;
  logic [CH_W-1:0]  idx;
  logic [1:0]       ctl_sel;
  logic             stat_rd;
  logic             pending_q, ovf_q;

  assign region  = region_e'(addr_i[CH_W+1:CH_W]);
  assign idx     = addr_i[CH_W-1:0];
  assign ctl_sel = addr_i[1:0];
  assign rd_ch_o = idx;
  assign pop_o   = re_i && region == RG_CTL && ctl_sel == CTL_POP;
  assign stat_rd = re_i && region == RG_CTL && ctl_sel == CTL_STAT;
  assign irq_o   = pending_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      frozen_o   <= 1'b0;
      all_mode_o <= 1'b0;
      deb_en_o   <= '0;
      stk_en_o   <= '0;
    end else if (we_i) begin
      case (region)
        RG_DEB: deb_en_o[idx] <= wdata_i[0];
        RG_STK: stk_en_o[idx] <= wdata_i[0];
        RG_CTL: begin
          if (ctl_sel == CTL_CMD) begin
            if (wdata_i[0])      frozen_o <= 1'b1;
            else if (wdata_i[1]) frozen_o <= 1'b0;
          end else if (ctl_sel == CTL_MODE) begin
            all_mode_o <= wdata_i[0];
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pending_q <= 1'b0;
      ovf_q     <= 1'b0;
    end else begin
      if (change_i)     pending_q <= 1'b1;
      else if (stat_rd) pending_q <= 1'b0;
      if (drop_i)       ovf_q <= 1'b1;
      else if (stat_rd) ovf_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
    end else if (re_i) begin
      case (region)
        RG_CHAN: rdata_o <= DW'(rd_nib_i);
        RG_DEB:  rdata_o <= DW'(deb_en_o[idx]);
        RG_STK:  rdata_o <= DW'(stk_en_o[idx]);
        default: begin
          case (ctl_sel)
            CTL_CMD:  rdata_o <= DW'(frozen_o);
            CTL_MODE: rdata_o <= DW'(all_mode_o);
            CTL_STAT: rdata_o <= DW'({ovf_q, empty_i, pending_q});
            default:  rdata_o <= pop_data_i;
          endcase
        end
      endcase
    end
  end

  AST_FRZ_ON: assert property (@(posedge clk) disable iff (rst)
    (we_i && region == RG_CTL && ctl_sel == CTL_CMD && wdata_i[0]) |=> frozen_o) else $error("freeze-on lost"); // R6
  AST_IRQ_SET: assert property (@(posedge clk) disable iff (rst)
    change_i |=> irq_o) else $error("change not flagged"); // R9
endmodule

// File: rtl/sig_debounce_buf.sv
module sig_debounce_buf
  import sdb_pkg::*;
#(
  parameter int NCH       = 32,
  parameter int STK_DEPTH = 32,
  parameter int CH_W      = $clog2(NCH),
  parameter int DW        = CH_W + ABCD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sig_upd_i,
  input  logic [CH_W-1:0]   sig_ch_i,
  input  logic [ABCD_W-1:0] sig_abcd_i,
  input  logic              mf_end_i,
  input  logic              host_we_i,
  input  logic              host_re_i,
  input  logic [CH_W+1:0]   host_addr_i,
  input  logic [1:0]        host_wdata_i,
  output logic [DW-1:0]     host_rdata_o,
  output logic              frz_o,
  output logic              irq_o
);
  logic [CH_W-1:0]     rd_ch;
  logic [2*ABCD_W-1:0] rd_nib;
  logic                push, pop, empty, drop, change, all_mode;
  logic [DW-1:0]       push_data, pop_data;
  logic [NCH-1:0]      deb_en, stk_en;

  sdb_chan_bank #(.NCH(NCH), .CH_W(CH_W)) u_bank (
    .clk(clk), .rst(rst),
    .upd_i(sig_upd_i), .upd_ch_i(sig_ch_i), .upd_abcd_i(sig_abcd_i),
    .mf_end_i(mf_end_i), .frozen_i(frz_o), .all_mode_i(all_mode),
    .deb_en_i(deb_en), .stk_en_i(stk_en),
    .rd_ch_i(rd_ch), .rd_nib_o(rd_nib),
    .push_o(push), .push_data_o(push_data), .change_o(change)
  );

  sdb_stack #(.DEPTH(STK_DEPTH), .DW(DW)) u_stack (
    .clk(clk), .rst(rst),
    .push_i(push), .push_data_i(push_data),
    .pop_i(pop), .pop_data_o(pop_data),
    .empty_o(empty), .drop_o(drop)
  );

  sdb_host #(.NCH(NCH), .CH_W(CH_W), .DW(DW)) u_host (
    .clk(clk), .rst(rst),
    .we_i(host_we_i), .re_i(host_re_i), .addr_i(host_addr_i), .wdata_i(host_wdata_i),
    .rd_nib_i(rd_nib), .pop_data_i(pop_data), .empty_i(empty),
    .drop_i(drop), .change_i(change),
    .rd_ch_o(rd_ch), .pop_o(pop), .frozen_o(frz_o), .all_mode_o(all_mode),
    .deb_en_o(deb_en), .stk_en_o(stk_en),
    .rdata_o(host_rdata_o), .irq_o(irq_o)
  );

  AST_FROZEN_NO_PUSH: assert property (@(posedge clk) disable iff (rst)
    $past(frz_o) |-> !push) else $error("push while frozen"); // R7
endmodule

// File: tb/sig_debounce_buf_tb.sv
module sig_debounce_buf_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sig_upd = 1'b0;
  logic [4:0] sig_ch = '0;
  logic [3:0] sig_abcd = '0;
  logic       mf_end = 1'b0;
  logic       we = 1'b0, re = 1'b0;
  logic [6:0] addr = '0;
  logic [1:0] wdata = '0;
  logic [8:0] rdata;
  logic       frz, irq;

  int n_chk = 0, n_bad = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sig_debounce_buf u_dut (
    .clk(clk), .rst(rst), .sig_upd_i(sig_upd), .sig_ch_i(sig_ch), .sig_abcd_i(sig_abcd),
    .mf_end_i(mf_end), .host_we_i(we), .host_re_i(re), .host_addr_i(addr),
    .host_wdata_i(wdata), .host_rdata_o(rdata), .frz_o(frz), .irq_o(irq)
  );

  // {new abcd, expected input, expected output} on debounced channel 5
  localparam logic [11:0] WALK [6] = '{
    {4'b1010, 4'b1010, 4'b0000},
    {4'b1010, 4'b1010, 4'b1010},
    {4'b0110, 4'b0110, 4'b1010},
    {4'b0110, 4'b0110, 4'b0110},
    {4'b0001, 4'b0001, 4'b0110},
    {4'b1001, 4'b1001, 4'b0001}
  };

  task automatic chk(string req, logic [8:0] act, logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hwr(logic [6:0] a, logic [1:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic hrd(logic [6:0] a, output logic [8:0] d);
    @(negedge clk); re = 1'b1; addr = a;
    @(negedge clk); re = 1'b0; d = rdata;
  endtask

  task automatic stage(logic [4:0] c, logic [3:0] v);
    @(negedge clk); sig_upd = 1'b1; sig_ch = c; sig_abcd = v;
    @(negedge clk); sig_upd = 1'b0;
  endtask

  task automatic sweep();
    @(negedge clk); mf_end = 1'b1;
    @(negedge clk); mf_end = 1'b0;
    repeat (36) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [8:0] d;
    logic [3:0] ev;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    hrd(7'h00, d); chk("R1 chan0", d, 9'h000);
    hrd(7'h62, d); chk("R1 status", d, 9'h002);
    chk("R1 frz", {8'h0, frz}, 9'h0);
    chk("R1 irq", {8'h0, irq}, 9'h0);

    // R5 R3 debounce walk on channel 5
    hwr(7'h25, 2'b01);
    foreach (WALK[i]) begin
      stage(5'd5, WALK[i][11:8]);
      sweep();
      hrd(7'h05, d);
      chk("R5 walk", d, {1'b0, WALK[i][3:0], WALK[i][7:4]});
    end
    hrd(7'h05, d); chk("R2 reread no side effect", d, 9'h019);

    // R4 direct copy, R2 write ignored
    stage(5'd7, 4'b1100);
    sweep();
    hrd(7'h07, d); chk("R4 copy", d, 9'h0CC);
    hwr(7'h07, 2'b11);
    hrd(7'h07, d); chk("R2 write ignored", d, 9'h0CC);

    // R8 change mode push, R9 pending
    hwr(7'h47, 2'b01);
    stage(5'd7, 4'b0011);
    sweep();
    chk("R9 irq set", {8'h0, irq}, 9'h1);
    hrd(7'h62, d); chk("R9 status", d, 9'h001);
    chk("R9 irq cleared", {8'h0, irq}, 9'h0);
    hrd(7'h63, d); chk("R10 pop", d, 9'h073);
    hrd(7'h63, d); chk("R10 empty pop", d, 9'h000);
    sweep();
    hrd(7'h62, d); chk("R8 no change no push", d, 9'h002);

    // R6 R7 freeze
    hwr(7'h60, 2'b01);
    chk("R6 frz on", {8'h0, frz}, 9'h1);
    stage(5'd7, 4'b0101);
    sweep();
    hrd(7'h07, d); chk("R7 frozen hold", d, 9'h033);
    hrd(7'h62, d); chk("R7 R9 frozen status", d, 9'h003);
    hwr(7'h60, 2'b10);
    chk("R6 frz off", {8'h0, frz}, 9'h0);
    hwr(7'h60, 2'b11);
    chk("R6 on priority", {8'h0, frz}, 9'h1);
    hwr(7'h60, 2'b10);

    // R8 all mode, R11 overflow, R10 order
    hwr(7'h61, 2'b01);
    for (int c = 0; c < 32; c++) hwr(7'h40 | 7'(c), 2'b01);
    sweep();
    hrd(7'h62, d); chk("R11 full no overflow", d, 9'h001);
    sweep();
    hrd(7'h62, d); chk("R11 overflow", d, 9'h004);
    hrd(7'h62, d); chk("R11 overflow cleared", d, 9'h000);
    for (int c = 0; c < 32; c++) begin
      ev = (c == 5) ? 4'b1001 : (c == 7) ? 4'b0101 : 4'b0000;
      hrd(7'h63, d); chk("R10 R8 order", d, {5'(c), ev});
    end
    hrd(7'h62, d); chk("R10 drained", d, 9'h002);

    // R12 second strobe during sweep ignored
    @(negedge clk); mf_end = 1'b1;
    @(negedge clk); mf_end = 1'b0;
    repeat (4) @(negedge clk);
    mf_end = 1'b1;
    @(negedge clk); mf_end = 1'b0;
    repeat (70) @(negedge clk);
    hrd(7'h62, d); chk("R12 single sweep", d, 9'h000);
    for (int c = 0; c < 32; c++) hrd(7'h63, d);
    hrd(7'h62, d); chk("R12 exactly one sweep", d, 9'h002);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule